// File: doc/BRIEF.md
# Random Table Update Engine

This engine applies a long run of scattered read-modify-write updates to a table in an external memory. The table holds a power-of-two number of 64-bit words. A 64-bit linear feedback shift register supplies one pseudo-random value for each update. The low bits of that value, masked down to the table size, select a word. The engine reads that word, XORs the same random value into it, and writes the result back.

A controller starts a job with one start pulse. The pulse carries a starting register value, the number of updates and the base-2 logarithm of the table size. Large runs can be split across engines or across time: each chunk starts from a precomputed position in the sequence. The engine keeps a single update in flight at a time, so two updates that hit the same word always see each other's result. When the last write has been accepted, the engine raises a one-cycle completion pulse. A running count of finished updates is visible the whole time.

The memory side is a request channel with a valid/ready handshake and a write flag, plus a response channel that returns read data with a one-cycle valid.

Top module: `rtu_engine`

## Requirements
- R1: The address of every request equals the current random value ANDed with (2^L − 1). L is the value of `log2_size_i` latched at start, and only the low `IDX_W` bits are driven. With L = 0, every access goes to address 0.
- R2: The write of an update goes to the same address as its read. The write data equals the read response data XOR the current random value.
- R3: Each update issues exactly one read request (`mem_req_write_o` = 0) and then exactly one write request (`mem_req_write_o` = 1). The write waits for the read response. The next read waits until the write handshake has completed.
- R4: One sequence step computes next = {v[62:0], 1'b0} XOR (v[63] ? 64'h7 : 0).
- R5: Update number k, counting from 1, uses the value reached after k steps from the latched seed. A seed of 1 therefore gives the canonical sequence.
- R6: A start pulse in idle latches the seed, the count and L. A start pulse while `busy_o` is high has no effect on the running job.
- R7: `done_o` is high for exactly one cycle, the cycle after the handshake of the last write, and `busy_o` is low from then on. A start with count 0 raises `done_o` in the next cycle and issues no memory request.
- R8: `updates_o` clears to 0 at an accepted start. It rises by one on each write handshake and holds its value after done.
- R9: A request that is valid while `mem_req_ready_i` is low stays valid in the next cycle, with the same address, write flag and write data.
- R10: After reset, `busy_o`, `done_o` and `mem_req_valid_o` are 0, and `updates_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job start pulse |
| seed_i | input | 64 | Starting sequence value |
| count_i | input | CNT_W | Number of updates in the job |
| log2_size_i | input | LOG_W | Base-2 log of the table size |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| updates_o | output | CNT_W | Updates completed in the current job |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_write_o | output | 1 | 1 = write, 0 = read |
| mem_req_addr_o | output | IDX_W | Table word address |
| mem_req_wdata_o | output | 64 | Write data |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 64 | Read data |

## Verification
The hardest case to produce is a run of updates that land on the same word while the memory stalls requests and varies its response delay. Only in that case would a missing read-after-write ordering corrupt the table. The stimulus produces it by setting the table size to one word, so every update collides, and by driving a ready pattern that stalls with changing read latency. The bench then sweeps L over every value from 0 to 8 with several seeds, including seeds with the top bit set so the feedback taps take effect. For each value of L it compares each request and the whole table against a shadow copy computed from the step formula.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2,
    ST_WR   = 2'd3
  } rtu_state_e;
endpackage

// File: rtl/rtu_lfsr.sv
module rtu_lfsr #(
  parameter int           W    = 64,
  parameter logic [W-1:0] TAPS = W'(7)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         adv_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q, val_d, base;

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0} ^ (v[W-1] ? TAPS : '0);
  endfunction

  always_comb begin
    base  = load_i ? load_val_i : val_q;
    val_d = val_q;
    if (load_i || adv_i) val_d = step(base);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtu_index.sv
module rtu_index #(
  parameter int IDX_W = 16,
  parameter int LOG_W = $clog2(IDX_W + 1)
) (
  input  logic [IDX_W-1:0] val_i,
  input  logic [LOG_W-1:0] log2_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] mask;

  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign mask[i] = (LOG_W'(i) < log2_i);
  end

  assign idx_o = val_i & mask;
endmodule

// File: rtl/rtu_fsm.sv
module rtu_fsm
  import rtu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             rd_cap_o,
  output logic             req_valid_o,
  output logic             req_write_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] updates_o
);
  rtu_state_e       state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] upd_q, upd_d;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    upd_d    = upd_q;
    done_d   = 1'b0;
    load_o   = 1'b0;
    adv_o    = 1'b0;
    rd_cap_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        upd_d  = '0;
        if (count_i == '0) begin
          done_d = 1'b1;
        end else begin
          remain_d = count_i;
          state_d  = ST_RD;
        end
      end
      ST_RD:   if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) begin
        rd_cap_o = 1'b1;
        state_d  = ST_WR;
      end
      ST_WR:   if (req_ready_i) begin
        upd_d = upd_q + 1'b1;
        if (remain_q == CNT_W'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          remain_d = remain_q - 1'b1;
          adv_o    = 1'b1;
          state_d  = ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      upd_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      upd_q    <= upd_d;
      done_q   <= done_d;
    end
  end

  assign req_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign req_write_o = (state_q == ST_WR);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign updates_o   = upd_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the update counter only steps by one or clears
  p_upd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(upd_q) |-> (upd_q == '0) || (upd_q == CNT_W'($past(upd_q) + 1'b1)));

  // R7: done never coincides with an active job
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);
endmodule

// File: rtl/rtu_engine.sv
module rtu_engine #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 32,
  parameter int LOG_W  = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] seed_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [LOG_W-1:0]  log2_size_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  updates_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_write_o,
  output logic [IDX_W-1:0]  mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  logic              load, adv, rd_cap;
  logic [DATA_W-1:0] rnd;
  logic [LOG_W-1:0]  log2_q;
  logic [DATA_W-1:0] wdata_q;

  rtu_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk, .rst_n,
    .start_i, .count_i,
    .req_ready_i (mem_req_ready_i),
    .rsp_valid_i (mem_rsp_valid_i),
    .load_o      (load),
    .adv_o       (adv),
    .rd_cap_o    (rd_cap),
    .req_valid_o (mem_req_valid_o),
    .req_write_o (mem_req_write_o),
    .busy_o, .done_o, .updates_o
  );

  rtu_lfsr #(.W(DATA_W), .TAPS(DATA_W'(7))) u_lfsr (
    .clk, .rst_n,
    .load_i     (load),
    .load_val_i (seed_i),
    .adv_i      (adv),
    .val_o      (rnd)
  );

  rtu_index #(.IDX_W(IDX_W), .LOG_W(LOG_W)) u_index (
    .val_i  (rnd[IDX_W-1:0]),
    .log2_i (log2_q),
    .idx_o  (mem_req_addr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log2_q  <= '0;
      wdata_q <= '0;
    end else begin
      if (load)   log2_q  <= log2_size_i;
      if (rd_cap) wdata_q <= mem_rsp_rdata_i ^ rnd;
    end
  end

  assign mem_req_wdata_o = wdata_q;

  // checker state: read address and read-response seen for the update in flight
  logic [IDX_W-1:0] chk_rd_addr_q;
  logic             chk_rsp_seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_rd_addr_q  <= '0;
      chk_rsp_seen_q <= 1'b0;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i && !mem_req_write_o)
        chk_rd_addr_q <= mem_req_addr_o;
      if (mem_rsp_valid_i && busy_o) chk_rsp_seen_q <= 1'b1;
      else if (mem_req_valid_o && mem_req_ready_i && mem_req_write_o)
        chk_rsp_seen_q <= 1'b0;
    end
  end

  // R1: addresses stay inside the latched table size
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> ((mem_req_addr_o >> log2_q) == '0));

  // R2: write targets the word that was read
  p_wr_same_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_write_o) |-> (mem_req_addr_o == chk_rd_addr_q));

  // R3: no write before the read data has returned
  p_rd_before_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && mem_req_write_o) |-> chk_rsp_seen_q);

  // R9: a stalled request is held unchanged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o &&
      $stable(mem_req_addr_o) && $stable(mem_req_write_o) && $stable(mem_req_wdata_o)));
endmodule

// File: tb/rtu_engine_tb.sv
module rtu_engine_tb_top;
  localparam int DW = 64;
  localparam int IW = 8;
  localparam int CW = 16;
  localparam int LW = $clog2(IW + 1);
  localparam int TSZ = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] seed_i = '0;
  logic [CW-1:0] count_i = '0;
  logic [LW-1:0] log2_size_i = '0;
  logic          busy_o, done_o;
  logic [CW-1:0] updates_o;
  logic          req_valid, req_write;
  logic [IW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_rdata = '0;

  always #10 clk = ~clk;

  rtu_engine #(.DATA_W(DW), .IDX_W(IW), .CNT_W(CW)) dut_i (
    .clk, .rst_n, .start_i, .seed_i, .count_i, .log2_size_i,
    .busy_o, .done_o, .updates_o,
    .mem_req_valid_o (req_valid),
    .mem_req_write_o (req_write),
    .mem_req_addr_o  (req_addr),
    .mem_req_wdata_o (req_wdata),
    .mem_req_ready_i (req_ready),
    .mem_rsp_valid_i (rsp_valid),
    .mem_rsp_rdata_i (rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nxt(input logic [DW-1:0] v);
    return {v[DW-2:0], 1'b0} ^ (v[DW-1] ? 64'h7 : 64'h0);
  endfunction

  // memory model
  logic [DW-1:0] mem [TSZ];
  logic [DW-1:0] shadow [TSZ];
  int            cyc = 0;
  bit            stall_en = 1'b0;
  bit            pend = 1'b0;
  int            pend_cnt = 0;
  logic [IW-1:0] pend_addr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_ready <= stall_en ? ((cyc % 3) != 1) && ((cyc % 7) != 4) : 1'b1;
    rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem[pend_addr];
        pend      <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (req_valid && req_ready) begin
      if (req_write) mem[req_addr] <= req_wdata;
      else begin
        pend      <= 1'b1;
        pend_cnt  <= stall_en ? (cyc % 4) : 0;
        pend_addr <= req_addr;
      end
    end
  end

  // monitor state
  bit            j_active = 1'b0;
  logic [DW-1:0] j_v = '0, j_mask = '0;
  int            j_k = 0, j_count = 0;
  bit            phase_wr = 1'b0;
  logic [IW-1:0] j_rd_addr = '0;
  bit            last_wr = 1'b0, done_seen = 1'b0, after_done = 1'b0;
  bit            held = 1'b0;
  logic [IW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic          h_write = 1'b0;

  always @(negedge clk) begin
    if (rst_n && j_active) begin
      if (held)
        chk(req_valid && req_addr == h_addr && req_write == h_write && req_wdata == h_wdata,
            "R9", "stalled request held", {req_valid, req_write, req_wdata[61:0]},
            {1'b1, h_write, h_wdata[61:0]});
      held    = req_valid && !req_ready;
      h_addr  = req_addr; h_write = req_write; h_wdata = req_wdata;
      if (after_done) begin
        chk(!done_o && !busy_o, "R7", "done lasts one cycle", {done_o, busy_o}, 0);
        chk(updates_o == CW'(j_count), "R8", "count held after done", updates_o, j_count);
        after_done = 1'b0; j_active = 1'b0;
      end else if (last_wr) begin
        chk(done_o && !busy_o, "R7", "done after last write", {done_o, busy_o}, 2);
        chk(updates_o == CW'(j_count), "R8", "final update count", updates_o, j_count);
        last_wr = 1'b0; done_seen = 1'b1; after_done = 1'b1;
      end else if (done_o) begin
        chk(1'b0, "R7", "early done", done_o, 0);
      end
      if (req_valid && req_ready) begin
        if (!req_write) begin
          chk(!phase_wr, "R3", "read while write expected", req_write, phase_wr);
          j_v = nxt(j_v);
          chk(req_addr == IW'(j_v & j_mask), "R1 R5", "read address", req_addr, j_v & j_mask);
          j_rd_addr = req_addr;
          phase_wr  = 1'b1;
        end else begin
          chk(phase_wr, "R3", "write without read", req_write, phase_wr);
          chk(req_addr == j_rd_addr, "R2", "write address", req_addr, j_rd_addr);
          chk(req_wdata == (shadow[j_rd_addr] ^ j_v), "R2 R4", "write data", req_wdata,
              shadow[j_rd_addr] ^ j_v);
          chk(updates_o == CW'(j_k), "R8", "running count", updates_o, j_k);
          shadow[j_rd_addr] = shadow[j_rd_addr] ^ j_v;
          j_k++;
          phase_wr = 1'b0;
          if (j_k == j_count) last_wr = 1'b1;
        end
      end
    end
  end

  task automatic run_job(input logic [DW-1:0] seed, input int count, input int lg,
                         input bit stall, input bit poke);
    int bad;
    stall_en  = stall;
    j_v       = seed;
    j_mask    = (64'h1 << lg) - 1;
    j_k       = 0; j_count = count; phase_wr = 0; done_seen = 0; held = 0;
    j_active  = 1'b1;
    seed_i = seed; count_i = CW'(count); log2_size_i = LW'(lg);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seed_i = '0; count_i = '0; log2_size_i = '0;
    chk(updates_o == '0, "R8", "cleared at start", updates_o, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy_o, "R6", "busy before poke", busy_o, 1);
      seed_i = 64'hdead_beef_0bad_f00d; count_i = CW'(1); log2_size_i = LW'(2);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int w = 0; w < 20000 && !done_seen; w++) @(negedge clk);
    if (!done_seen) chk(1'b0, "R7", "job never finished", 0, 1);
    @(negedge clk);
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < TSZ; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, "R2 R3", "table contents", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < TSZ; i++) begin
      mem[i]    = {32'(i) * 32'h9e37_79b9, 32'(i) ^ 32'h5a5a_0000};
      shadow[i] = {32'(i) * 32'h9e37_79b9, 32'(i) ^ 32'h5a5a_0000};
    end
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !req_valid && updates_o == '0, "R10", "reset state",
        {busy_o, done_o, req_valid, updates_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !req_valid, "R10", "idle after reset release", {busy_o, req_valid}, 0);

    run_job(64'h1, 20, 8, 1'b0, 1'b0);
    run_job(64'h1, 20, 3, 1'b1, 1'b1);
    run_job(64'h8000_0000_0000_0001, 30, 0, 1'b1, 1'b0);
    run_job(64'hffff_ffff_ffff_ffff, 25, 8, 1'b1, 1'b0);
    for (int lg = 0; lg <= IW; lg++)
      run_job(64'(lg) * 64'hf123_4567_89ab_cdef + 1, 12, lg, lg[0], lg == 5);
    run_job(64'h5, 1, 1, 1'b0, 1'b0);

    // zero-length job
    seed_i = 64'h3; count_i = '0; log2_size_i = LW'(4);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !busy_o && !req_valid, "R7", "count zero done", {done_o, busy_o, req_valid}, 4);
    @(negedge clk);
    chk(!done_o && !req_valid && updates_o == '0, "R7", "count zero no request",
        {done_o, req_valid, updates_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule